// File: doc/BRIEF.md
# Sector Write-Lock Register with Pin Overrides

This block keeps one lock flag per sector of a flash array. It decides, for any sector address placed on its query port, whether that sector may currently be written. The lock flags change only through a command sequence written on the bus. The sequence opens with two writes of the lock command byte, at any address. It continues with one or more sector-select writes. In each of these, a single address bit chooses whether the addressed sector is locked or unlocked. The sequence closes with an exit byte.

Two hardware inputs can override the stored flags. A low write-protect pin forces the two outermost sectors (the lowest and the highest) to read as locked. Two supply-level inputs force the whole array locked or unlocked. The program and erase engines read the query result and do not belong to this block.

Top module: `sector_lock_guard`

## Requirements
- R1: After reset, every sector lock flag is set, so every query returns not writable while no override is active.
- R2: The flags are reached only after two consecutive bus writes with data 60h. The address of those two writes has no effect. A third write with data 60h then selects the sector from address bits [ADDR_W-1:ADDR_W-SECT_W].
- R3: In a sector-select write, address bit POL_BIT (bit 6) low sets the sector's lock flag, and bit 6 high clears it. The new flag is visible on the query output in the cycle after the write.
- R4: Once the sequence is open, each further write with data 60h updates the flag of the sector it addresses, with no new pair of 60h writes. A single write never changes more than one flag.
- R5: A write with data F0h closes the sequence from any state. A following single 60h write then changes no flag.
- R6: If a write other than 60h arrives while only one 60h write has been received, the sequence is dropped and no flag changes.
- R7: While wp_n is low, sectors 0 and NUM_SECT-1 read as not writable, whatever their flags hold. All other sectors are unaffected.
- R8: While vpp_low is high, every sector reads as not writable.
- R9: While vpp_high is high and vpp_low is low, every sector reads as writable, even with wp_n low.
- R10: Priority: vpp_low comes first, then vpp_high, then wp_n, then the stored flag.
- R11: In the open sequence, a write whose data is neither 60h nor F0h changes no flag, and the sequence stays open.
- R12: If the write after the two 60h writes carries data other than 60h, no flag changes and the sequence is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data byte |
| wp_n | input | 1 | Write-protect pin, active low, guards the outermost sectors |
| vpp_low | input | 1 | Supply at the low level: lock all sectors |
| vpp_high | input | 1 | Supply at the high level: unlock all sectors |
| query_addr | input | ADDR_W | Address whose sector is being asked about |
| query_writable | output | 1 | High when the queried sector may be written |

## Verification
The assertions check the override rules on every cycle: forced lock under vpp_low, forced unlock under vpp_high, and the guarded outermost sectors under wp_n. They also check that a flag never moves unless the sequence has been armed, that at most one flag changes per cycle, and that the exit byte always closes the sequence. Only the bench scenarios can show whether the right flag moves with the right polarity. The same holds for the open sequence surviving stray bytes, and for dropped preambles at their exact positions. The bench compares each cycle against a behavioural model and sweeps every sector after each step.

// File: rtl/sector_lock_guard.sv
module sector_lock_guard #(
  parameter int NUM_SECT = 16,
  parameter int ADDR_W   = 12,
  parameter int POL_BIT  = 6,
  parameter logic [7:0] CMD_LOCK = 8'h60,
  parameter logic [7:0] CMD_EXIT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wp_n,
  input  logic              vpp_low,
  input  logic              vpp_high,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_writable
);
  localparam int SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int SECT_LSB = ADDR_W - SECT_W;
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_ARM1 = 2'd1;
  localparam logic [1:0] S_ARM2 = 2'd2;
  localparam logic [1:0] S_OPEN = 2'd3;

  logic [NUM_SECT-1:0] lock_q;
  logic [1:0]          seq_q, seq_d;
  logic [SECT_W-1:0]   wr_sect, q_sect;
  logic                is_lock, is_exit, apply;

  assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];
  assign q_sect  = query_addr[ADDR_W-1 -: SECT_W];
  assign is_lock = wr_en && (wr_data == CMD_LOCK);
  assign is_exit = wr_en && (wr_data == CMD_EXIT);
  assign apply   = is_lock && (seq_q == S_ARM2 || seq_q == S_OPEN);

  always_comb begin
    seq_d = seq_q;
    if (is_exit) seq_d = S_IDLE;
    else if (wr_en) begin
      case (seq_q)
        S_IDLE:  seq_d = is_lock ? S_ARM1 : S_IDLE;
        S_ARM1:  seq_d = is_lock ? S_ARM2 : S_IDLE;
        S_ARM2:  seq_d = is_lock ? S_OPEN : S_IDLE;
        default: seq_d = S_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= S_IDLE;
      lock_q <= '1;
    end else begin
      seq_q <= seq_d;
      for (int i = 0; i < NUM_SECT; i++)
        if (apply && wr_sect == SECT_W'(i)) lock_q[i] <= ~wr_addr[POL_BIT];
    end
  end

  logic q_boot;
  assign q_boot = (q_sect == '0) || (q_sect == SECT_W'(NUM_SECT-1));

  assign query_writable = vpp_low          ? 1'b0 :
                          vpp_high         ? 1'b1 :
                          (!wp_n && q_boot) ? 1'b0 :
                          ~lock_q[q_sect];
endmodule

module sector_lock_guard_chk #(
  parameter int NUM_SECT = 16,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [7:0]          wr_data,
  input logic                wp_n,
  input logic                vpp_low,
  input logic                vpp_high,
  input logic [ADDR_W-1:0]   query_addr,
  input logic                query_writable,
  input logic [NUM_SECT-1:0] lock_q,
  input logic [1:0]          seq_q
);
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  logic [SECT_W-1:0] qs;
  assign qs = query_addr[ADDR_W-1 -: SECT_W];

  AST_VPP_LOW_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_low |-> !query_writable); // R8
  AST_VPP_HIGH_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_high && !vpp_low) |-> query_writable); // R9
  AST_WP_GUARDS_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_low && !vpp_high && !wp_n && (qs == '0 || qs == SECT_W'(NUM_SECT-1))) |-> !query_writable); // R7
  AST_NO_CHANGE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == 2'd0 || seq_q == 2'd1) |=> $stable(lock_q)); // R6
  AST_ONE_FLAG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(lock_q ^ $past(lock_q)) <= 1)); // R4
  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hF0) |=> (seq_q == 2'd0)); // R5
endmodule

bind sector_lock_guard sector_lock_guard_chk #(.NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wp_n(wp_n),
  .vpp_low(vpp_low), .vpp_high(vpp_high), .query_addr(query_addr),
  .query_writable(query_writable), .lock_q(lock_q), .seq_q(seq_q)
);

// File: tb/sector_lock_guard_bench.sv
`timescale 1ns/1ps
module sector_lock_guard_bench;
  localparam int NS = 16;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wp_n = 1'b1, vpp_low = 1'b0, vpp_high = 1'b0;
  logic [AW-1:0] query_addr = '0;
  logic query_writable;

  int n_cmp = 0, n_bad = 0;
  bit ref_lock[NS];
  int ref_st = 0;

  always #2.5 clk = ~clk;

  sector_lock_guard u_sector_lock_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wp_n(wp_n), .vpp_low(vpp_low), .vpp_high(vpp_high),
    .query_addr(query_addr), .query_writable(query_writable)
  );

  initial for (int i = 0; i < NS; i++) ref_lock[i] = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) ref_lock[i] = 1'b1;
      ref_st = 0;
    end else if (wr_en) begin
      if (wr_data == 8'hF0) ref_st = 0;
      else if (ref_st == 3) begin
        if (wr_data == 8'h60) ref_lock[wr_addr / 256] = (((wr_addr / 64) % 2) == 0);
      end else if (wr_data == 8'h60) begin
        if (ref_st == 2) ref_lock[wr_addr / 256] = (((wr_addr / 64) % 2) == 0);
        ref_st = ref_st + 1;
      end else ref_st = 0;
    end
  end

  function automatic bit expect_wr(int sect);
    if (vpp_low) return 1'b0;
    if (vpp_high) return 1'b1;
    if (!wp_n && (sect == 0 || sect == NS-1)) return 1'b0;
    return !ref_lock[sect];
  endfunction

  task automatic compare(string req);
    bit exp_v;
    exp_v = expect_wr(query_addr / 256);
    n_cmp++;
    if (query_writable !== exp_v) begin
      n_bad++;
      $display("FAIL %s sector %0d: actual %b expected %b", req, query_addr / 256, query_writable, exp_v);
    end
  endtask

  task automatic step(bit we, int addr, int data, string req);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(addr); wr_data = 8'(data);
    #1 compare(req);
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      wr_en = 1'b0; query_addr = AW'(s * 256 + 5);
      #1 compare(req);
    end
  endtask

  function automatic int sa(int sect, bit unlock);
    return sect * 256 + (unlock ? 64 : 0) + 3;
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");
    step(1, 12'h7A5, 8'h60, "R2");
    step(1, 12'h013, 8'h60, "R2");
    step(1, sa(3, 1), 8'h60, "R3");
    sweep("R2");
    step(1, sa(5, 1), 8'h60, "R4");
    step(1, sa(3, 0), 8'h60, "R4");
    step(1, sa(0, 1), 8'h60, "R4");
    step(1, sa(15, 1), 8'h60, "R4");
    sweep("R3");
    step(1, sa(7, 1), 8'h55, "R11");
    sweep("R11");
    step(1, sa(7, 1), 8'h60, "R11");
    sweep("R11");
    step(1, 0, 8'hF0, "R5");
    step(1, sa(9, 1), 8'h60, "R5");
    sweep("R5");
    step(1, 0, 8'h60, "R5");
    step(1, sa(9, 1), 8'h60, "R5");
    sweep("R5");
    step(1, 0, 8'hF0, "R6");
    step(1, 0, 8'h60, "R6");
    step(1, sa(10, 1), 8'h90, "R6");
    step(1, sa(10, 1), 8'h60, "R6");
    sweep("R6");
    step(1, 0, 8'h60, "R6");
    step(1, sa(10, 1), 8'h60, "R6");
    sweep("R6");
    step(1, 0, 8'hF0, "R12");
    step(1, 0, 8'h60, "R12");
    step(1, 0, 8'h60, "R12");
    step(1, sa(11, 1), 8'hA0, "R12");
    step(1, sa(11, 1), 8'h60, "R12");
    sweep("R12");
    wp_n = 1'b0;
    sweep("R7");
    vpp_low = 1'b1;
    sweep("R8");
    vpp_low = 1'b0; vpp_high = 1'b1;
    sweep("R9");
    vpp_low = 1'b1;
    sweep("R10");
    vpp_low = 1'b0; vpp_high = 1'b0; wp_n = 1'b1;
    sweep("R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule